// File: doc/BRIEF.md
# Record/Playback Memory Address Sequencer

This block produces the 14-bit memory address used while a streaming record, playback or erase operation runs. The address splits into an 11-bit sector number (bits 13..3) and a 3-bit page number (bits 2..0); each page is one unit of sample storage. A pulse on `page_adv` marks the end of the current page, and the sequencer then moves to the next address, to a block the host has queued, or ends the operation.

It has two modes. In sequential mode it runs from the start register to the stop register. In random mode memory is handled in blocks of 2, 4, 8 or 16 sectors. Once the first sector of a block has passed, a next-address request asks the host for the block to jump to when the current block ends. If no address arrives in time, it carries on into the adjacent block. Stop commands end at page boundaries. A record or erase then drains through the following sector, and a playback winds down after a fixed number of cycles. Pause suspends and resumes the run.

The block has no streaming data path. All of its pins are plain control and status levels or one-cycle pulses, so no back-pressure rules apply.

Top module: `sqr_addr_seq`

## Requirements
- R1: Each `page_adv` pulse in a running, unpaused operation moves `cur_addr` up by one. A sequential operation ends, with `busy` falling, on the advance taken while `cur_addr` equals the stop register.
- R2: On an accepted start, record (`op_kind`=00) and erase (`op_kind`=10) load the start register with bits 2..0 forced to zero. Playback (`op_kind`=01) loads all 14 bits.
- R3: After reset the start register is 0 and the stop register is 0x3FFF. Registers not rewritten keep their last written value for later operations.
- R4: `nar` stays low whenever `mode_rand` is 0.
- R5: In random mode `nar` is high while running with a nonzero sector offset inside the current block. The block spans 2^(`blk_size`+1) sectors (`blk_size` 00=2, 01=4, 10=8, 11=16). A start-address write while `nar` is high queues that address with its low `blk_size`+4 bits cleared, and `nar` is low on the next cycle.
- R6: In random mode the advance out of the last page of a block jumps to the queued block base if one is queued. If none is queued, it continues to the next address.
- R7: `stop_cmd` during record or erase keeps `busy` high. Advances continue until the last page of the sector after the one current at the stop. The advance taken there ends the operation.
- R8: `stop_cmd` during playback ends the operation `STOP_CYC` clock cycles after the stop is sampled, with no further address change.
- R9: `pause_cmd` while running toggles `paused`, and advances are ignored while paused. `stop_cmd` while paused clears `paused` and starts the stop sequence of R7/R8.
- R10: The advance taken at address 0x3FFF ends any running operation, even when that is also the stop address, and sets `full` in the same cycle that `busy` falls. `full` clears on the next accepted start.
- R11: `rd_addr` shows the value just written after a start or stop register write. It returns to `cur_addr` after the next `page_adv` or accepted start.
- R12: `op_start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_rand | input | 1 | 0 sequential, 1 random block mode |
| blk_size | input | 2 | Sectors per block code: 00=2, 01=4, 10=8, 11=16 |
| op_start | input | 1 | Start pulse for the operation in op_kind |
| op_kind | input | 2 | 00 record, 01 playback, 10 erase |
| stadr_wr | input | 1 | Start register write strobe |
| stadr_data | input | 14 | Start address value |
| spadr_wr | input | 1 | Stop register write strobe |
| spadr_data | input | 14 | Stop address value |
| page_adv | input | 1 | End-of-page advance pulse |
| stop_cmd | input | 1 | Stop command pulse |
| pause_cmd | input | 1 | Pause/resume toggle pulse |
| cur_addr | output | 14 | Current memory address |
| rd_addr | output | 14 | Readable address (current or just written) |
| nar | output | 1 | Next-address request |
| full | output | 1 | Last memory address was reached |
| busy | output | 1 | Operation in progress |
| paused | output | 1 | Operation suspended |

## Verification
The bench targets the random-mode block boundaries. A queued address must have its low bits masked to the block size, or the jump lands inside a block. The jump must happen exactly on the advance out of the block's last page, and a design that jumps early or ignores the queue shows the wrong `cur_addr`. The stop drains are counted edge by edge, so a drain that ends one page early or late, or a playback halt of the wrong length, shows up on `busy`. The case where the stop address equals the last memory address checks that `full` still rises. A design that tested the stop address first would leave `full` low.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  typedef enum logic [1:0] {
    OP_REC   = 2'b00,
    OP_PLAY  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_DRAIN = 2'b10,
    ST_HALT  = 2'b11
  } seq_state_e;
endpackage

// File: rtl/sqr_addr_regs.sv
module sqr_addr_regs #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stadr_wr,
  input  logic [ADDR_W-1:0] stadr_data,
  input  logic              spadr_wr,
  input  logic [ADDR_W-1:0] spadr_data,
  input  logic              page_adv,
  input  logic              op_go,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] stop_q,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic              show_wr;
  logic [ADDR_W-1:0] last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= TOP_ADDR;
      show_wr <= 1'b0;
      last_wr <= '0;
    end else begin
      if (stadr_wr) start_q <= stadr_data;
      if (spadr_wr) stop_q  <= spadr_data;
      if (spadr_wr) begin
        show_wr <= 1'b1;
        last_wr <= spadr_data;
      end else if (stadr_wr) begin
        show_wr <= 1'b1;
        last_wr <= stadr_data;
      end else if (page_adv || op_go) begin
        show_wr <= 1'b0;
      end
    end
  end

  assign rd_addr = show_wr ? last_wr : cur;

  p_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stadr_wr && !spadr_wr) |=> (rd_addr == $past(stadr_data)));
endmodule

// File: rtl/sqr_blk_ctl.sv
module sqr_blk_ctl #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 3,
  parameter int BS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rand,
  input  logic [BS_W-1:0]   blk_size,
  input  logic [ADDR_W-1:0] cur,
  input  logic              run_active,
  input  logic              stadr_wr,
  input  logic [ADDR_W-1:0] stadr_data,
  input  logic              jump_take,
  input  logic              op_go,
  output logic              nar,
  output logic              blk_end,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_base
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

  logic [ADDR_W-1:0] blk_mask;
  logic              in_later_sector;

  always_comb begin
    blk_mask = (ONE << (PAGE_W + 1 + int'(blk_size))) - ONE;
  end

  assign in_later_sector = ((cur & blk_mask & ~PAGE_MASK) != '0);
  assign blk_end         = ((cur & blk_mask) == blk_mask);
  assign nar             = mode_rand && run_active && in_later_sector && !pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_base <= '0;
    end else if (op_go || jump_take) begin
      pend_vld <= 1'b0;
    end else if (stadr_wr && nar) begin
      pend_vld  <= 1'b1;
      pend_base <= stadr_data & ~blk_mask;
    end
  end

  p_nar_seq_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rand |-> !nar);
  p_nar_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stadr_wr && nar && !jump_take && !op_go) |=> !nar);
endmodule

// File: rtl/sqr_fsm.sv
module sqr_fsm
  import sqr_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int PAGE_W   = 3,
  parameter int STOP_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rand,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] start_q,
  input  logic [ADDR_W-1:0] stop_q,
  input  logic              page_adv,
  input  logic              stop_cmd,
  input  logic              pause_cmd,
  input  logic              blk_end,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_base,
  output logic [ADDR_W-1:0] cur,
  output logic              busy,
  output logic              full,
  output logic              paused,
  output logic              op_go,
  output logic              jump_take,
  output logic              run_active
);
  localparam int SEC_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(STOP_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [CNT_W-1:0]  HALT_END  = CNT_W'(STOP_CYC - 1);

  seq_state_e        state;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] drain_end;
  logic [CNT_W-1:0]  halt_cnt;
  logic [SEC_W-1:0]  cur_sec;
  logic [ADDR_W-1:0] next_drain_end;
  logic [ADDR_W-1:0] load_addr;
  logic              step_ok;

  assign cur_sec    = cur[ADDR_W-1:PAGE_W];
  assign op_go      = op_start && (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign run_active = (state == ST_RUN);
  assign step_ok    = run_active && page_adv && !paused && !stop_cmd && !pause_cmd;
  assign jump_take  = step_ok && (cur != LAST_ADDR) && (cur != stop_q) &&
                      mode_rand && blk_end && pend_vld;

  always_comb begin
    if (&cur_sec) next_drain_end = LAST_ADDR;
    else          next_drain_end = {cur_sec + SEC_W'(1), {PAGE_W{1'b1}}};
    if (op_kind_e'(op_kind) == OP_PLAY) load_addr = start_q;
    else load_addr = {start_q[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind_q    <= OP_REC;
      cur       <= '0;
      full      <= 1'b0;
      paused    <= 1'b0;
      drain_end <= '0;
      halt_cnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (op_go) begin
            state  <= ST_RUN;
            kind_q <= op_kind_e'(op_kind);
            cur    <= load_addr;
            full   <= 1'b0;
            paused <= 1'b0;
          end
        end
        ST_RUN: begin
          if (stop_cmd) begin
            paused <= 1'b0;
            if (kind_q == OP_PLAY) begin
              state    <= ST_HALT;
              halt_cnt <= '0;
            end else begin
              state     <= ST_DRAIN;
              drain_end <= next_drain_end;
            end
          end else if (pause_cmd) begin
            paused <= !paused;
          end else if (page_adv && !paused) begin
            if (cur == LAST_ADDR) begin
              state <= ST_IDLE;
              full  <= 1'b1;
            end else if (cur == stop_q) begin
              state <= ST_IDLE;
            end else if (jump_take) begin
              cur <= pend_base;
            end else begin
              cur <= cur + ADDR_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (page_adv) begin
            if ((cur == drain_end) || (cur == LAST_ADDR)) state <= ST_IDLE;
            else cur <= cur + ADDR_W'(1);
          end
        end
        ST_HALT: begin
          if (halt_cnt == HALT_END) state <= ST_IDLE;
          else halt_cnt <= halt_cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_rec_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_kind_e'(op_kind) != OP_PLAY) |=> (cur[PAGE_W-1:0] == '0));
  p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !stop_cmd) |=> $stable(cur));
  p_pause_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> run_active);
  p_full_with_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $fell(busy));
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && busy && !page_adv && !stop_cmd) |=> $stable(cur));
endmodule

// File: rtl/sqr_addr_seq.sv
module sqr_addr_seq #(
  parameter int ADDR_W   = 14,
  parameter int PAGE_W   = 3,
  parameter int BS_W     = 2,
  parameter int STOP_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rand,
  input  logic [BS_W-1:0]   blk_size,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic              stadr_wr,
  input  logic [ADDR_W-1:0] stadr_data,
  input  logic              spadr_wr,
  input  logic [ADDR_W-1:0] spadr_data,
  input  logic              page_adv,
  input  logic              stop_cmd,
  input  logic              pause_cmd,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              nar,
  output logic              full,
  output logic              busy,
  output logic              paused
);
  logic [ADDR_W-1:0] start_q, stop_q, pend_base;
  logic              op_go, jump_take, run_active, blk_end, pend_vld;

  sqr_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .stadr_wr(stadr_wr), .stadr_data(stadr_data),
    .spadr_wr(spadr_wr), .spadr_data(spadr_data),
    .page_adv(page_adv), .op_go(op_go), .cur(cur_addr),
    .start_q(start_q), .stop_q(stop_q), .rd_addr(rd_addr)
  );

  sqr_blk_ctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BS_W(BS_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .mode_rand(mode_rand), .blk_size(blk_size),
    .cur(cur_addr), .run_active(run_active),
    .stadr_wr(stadr_wr), .stadr_data(stadr_data),
    .jump_take(jump_take), .op_go(op_go),
    .nar(nar), .blk_end(blk_end), .pend_vld(pend_vld), .pend_base(pend_base)
  );

  sqr_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .STOP_CYC(STOP_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_rand(mode_rand),
    .op_start(op_start), .op_kind(op_kind),
    .start_q(start_q), .stop_q(stop_q),
    .page_adv(page_adv), .stop_cmd(stop_cmd), .pause_cmd(pause_cmd),
    .blk_end(blk_end), .pend_vld(pend_vld), .pend_base(pend_base),
    .cur(cur_addr), .busy(busy), .full(full), .paused(paused),
    .op_go(op_go), .jump_take(jump_take), .run_active(run_active)
  );

  p_nar_only_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nar |-> (busy && mode_rand));
endmodule

// File: tb/tb_sqr_addr_seq.sv
module tb_sqr_addr_seq;
  localparam int STOP_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_rand = 1'b0;
  logic [1:0]  blk_size = 2'b00;
  logic        op_start = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic        stadr_wr = 1'b0;
  logic [13:0] stadr_data = '0;
  logic        spadr_wr = 1'b0;
  logic [13:0] spadr_data = '0;
  logic        page_adv = 1'b0;
  logic        stop_cmd = 1'b0;
  logic        pause_cmd = 1'b0;
  logic [13:0] cur_addr, rd_addr;
  logic        nar, full, busy, paused;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sqr_addr_seq #(.STOP_CYC(STOP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .mode_rand(mode_rand), .blk_size(blk_size),
    .op_start(op_start), .op_kind(op_kind),
    .stadr_wr(stadr_wr), .stadr_data(stadr_data),
    .spadr_wr(spadr_wr), .spadr_data(spadr_data),
    .page_adv(page_adv), .stop_cmd(stop_cmd), .pause_cmd(pause_cmd),
    .cur_addr(cur_addr), .rd_addr(rd_addr), .nar(nar), .full(full),
    .busy(busy), .paused(paused)
  );

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_start(input logic [13:0] a);
    @(negedge clk); stadr_wr = 1'b1; stadr_data = a;
    @(negedge clk); stadr_wr = 1'b0;
  endtask

  task automatic wr_stop(input logic [13:0] a);
    @(negedge clk); spadr_wr = 1'b1; spadr_data = a;
    @(negedge clk); spadr_wr = 1'b0;
  endtask

  task automatic go(input logic [1:0] k);
    @(negedge clk); op_start = 1'b1; op_kind = k;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); page_adv = 1'b1;
      @(negedge clk); page_adv = 1'b0;
    end
  endtask

  task automatic do_stop();
    @(negedge clk); stop_cmd = 1'b1;
    @(negedge clk); stop_cmd = 1'b0;
  endtask

  task automatic do_pause();
    @(negedge clk); pause_cmd = 1'b1;
    @(negedge clk); pause_cmd = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset cur", cur_addr, 14'h0);
    chk("R3 reset busy", {13'b0, busy}, 14'h0);
    chk("R4 reset nar", {13'b0, nar}, 14'h0);
    chk("R10 reset full", {13'b0, full}, 14'h0);
  endtask

  task automatic t_full();
    wr_start(14'h3FFC);
    go(2'b01);
    chk("R2 play start full res", cur_addr, 14'h3FFC);
    adv(3);
    chk("R1 advance to last", cur_addr, 14'h3FFF);
    chk("R10 busy before end", {13'b0, busy}, 14'h1);
    chk("R10 full before end", {13'b0, full}, 14'h0);
    adv(1);
    chk("R3 default stop ends at top", {13'b0, busy}, 14'h0);
    chk("R10 full set", {13'b0, full}, 14'h1);
  endtask

  task automatic t_seq_record();
    mode_rand = 1'b0;
    wr_stop(14'h0012);
    wr_start(14'h0015);
    go(2'b00);
    chk("R2 record start aligned", cur_addr, 14'h0010);
    chk("R10 full cleared on start", {13'b0, full}, 14'h0);
    adv(2);
    chk("R1 seq step", cur_addr, 14'h0012);
    chk("R4 nar low seq", {13'b0, nar}, 14'h0);
    chk("R1 still busy at stop page", {13'b0, busy}, 14'h1);
    adv(1);
    chk("R1 ends after stop page", {13'b0, busy}, 14'h0);
  endtask

  task automatic t_play_stop();
    mode_rand = 1'b0;
    wr_stop(14'h3FFF);
    wr_start(14'h0015);
    go(2'b01);
    chk("R2 play start keeps page", cur_addr, 14'h0015);
    go(2'b00);
    chk("R12 start while busy ignored", cur_addr, 14'h0015);
    do_stop();
    repeat (STOP_CYC - 1) @(negedge clk);
    chk("R8 halting busy", {13'b0, busy}, 14'h1);
    @(negedge clk);
    chk("R8 halt done", {13'b0, busy}, 14'h0);
    chk("R8 address unchanged", cur_addr, 14'h0015);
  endtask

  task automatic t_readback();
    wr_start(14'h0123);
    chk("R11 start readback", rd_addr, 14'h0123);
    wr_stop(14'h3FFF);
    chk("R11 stop readback", rd_addr, 14'h3FFF);
    adv(1);
    chk("R11 readback returns to current", rd_addr, 14'h0015);
  endtask

  task automatic t_random2();
    mode_rand = 1'b1; blk_size = 2'b00;
    wr_start(14'h0020);
    go(2'b00);
    chk("R5 nar low first sector", {13'b0, nar}, 14'h0);
    adv(8);
    chk("R5 cur second sector", cur_addr, 14'h0028);
    chk("R5 nar high second sector", {13'b0, nar}, 14'h1);
    wr_start(14'h0135);
    chk("R5 nar dropped by write", {13'b0, nar}, 14'h0);
    adv(7);
    chk("R6 no jump before block end", cur_addr, 14'h002F);
    adv(1);
    chk("R6 jump to masked block", cur_addr, 14'h0130);
    adv(8);
    chk("R5 nar high again", {13'b0, nar}, 14'h1);
    adv(8);
    chk("R6 continue without address", cur_addr, 14'h0140);
    do_stop();
    adv(15);
    chk("R7 drain busy", {13'b0, busy}, 14'h1);
    adv(1);
    chk("R7 drain end", {13'b0, busy}, 14'h0);
  endtask

  task automatic t_random16();
    mode_rand = 1'b1; blk_size = 2'b11;
    wr_start(14'h0200);
    go(2'b00);
    adv(8);
    chk("R5 nar high 16-sector block", {13'b0, nar}, 14'h1);
    wr_start(14'h0ABF);
    adv(119);
    chk("R6 last page of big block", cur_addr, 14'h027F);
    adv(1);
    chk("R5 low seven bits ignored", cur_addr, 14'h0A80);
    do_pause();
    chk("R9 paused", {13'b0, paused}, 14'h1);
    adv(1);
    chk("R9 advance ignored", cur_addr, 14'h0A80);
    do_pause();
    chk("R9 resumed", {13'b0, paused}, 14'h0);
    adv(1);
    chk("R9 advance after resume", cur_addr, 14'h0A81);
    do_pause();
    do_stop();
    chk("R9 stop clears pause", {13'b0, paused}, 14'h0);
    adv(14);
    chk("R7 drain reaches next sector end", cur_addr, 14'h0A8F);
    chk("R7 drain still busy", {13'b0, busy}, 14'h1);
    adv(1);
    chk("R7 stop from pause ends", {13'b0, busy}, 14'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_full();
    t_seq_record();
    t_play_stop();
    t_readback();
    t_random2();
    t_random16();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule